// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker drives one memory-to-stream channel through a linked chain of descriptors held in system memory. Software points it at the first descriptor, sets the run input and writes a tail pointer; the tail write clears the idle flag and the walker begins. For each descriptor it reads the eleven 32-bit words one at a time over a simple request/acknowledge memory port. It then checks the complete flag, hands the buffer address, length and frame flags to an external data mover and waits for that mover to finish. After that it writes the status word back, pulses a completion strobe and follows the link to the next descriptor.

The walk halts in one of two ways. It halts when a fetched descriptor is already marked complete, and in that case it moves no data and writes nothing. It also halts when the descriptor just finished sits at the tail address. A completion strobe is issued once per written-back descriptor, so a downstream interrupt-coalescing counter can use it directly.

Top module: `sgw_walker`

## Requirements
- R1: After reset `idle` is 1 and `mem_req`, `mv_req` and `cmpl_pulse` are 0.
- R2: While `run` is 0, or while `idle` is 1, no descriptor fetch is started (`mem_req` stays 0).
- R3: A fetch issues eleven reads, in ascending order, at byte addresses current pointer + 4*k for k = 0..10. Words 0/1 are the buffer address low/high, 2/3 the next pointer low/high, 4 control, 5 status and 6..10 the application words. The address is held while a request waits for acknowledge.
- R4: While the mover is busy, `mv_addr` is the 64-bit buffer address and `mv_len` is control bits 22:0. `mv_sof` is control bit 27 and `mv_last` is control bit 26. `mv_req` stays high until `mv_done`.
- R5: Application words 6..10 are captured only from a descriptor with control bit 27 set, and `mv_app` keeps them (word k at bits 32k+31:32k) for the later descriptors of that packet.
- R6: Write-back is a single write to current pointer + 20 with data equal to the length OR 0x8000_0000.
- R7: `cmpl_pulse` is high for exactly the one cycle in which the write-back is acknowledged, and at no other time.
- R8: After write-back the current pointer takes the next-descriptor value. If the descriptor just finished was at the tail address, `idle` becomes 1; otherwise the walk continues.
- R9: A fetched descriptor whose status bit 31 is already set makes `idle` 1, with no mover request and no write.
- R10: A tail write in the same cycle as the tail comparison wins: `idle` stays 0 and the walk continues with the next descriptor.
- R11: A tail write clears `idle`, and with `run` high the walk starts from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Channel run enable |
| cur_wr | input | 1 | Load current pointer (honoured only when not walking) |
| cur_addr | input | ADDR_W | New current pointer |
| tail_wr | input | 1 | Tail pointer write strobe; clears idle |
| tail_addr | input | ADDR_W | New tail pointer |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| mv_req | output | 1 | Transfer request to data mover |
| mv_addr | output | ADDR_W | Buffer address |
| mv_len | output | 23 | Transfer length in bytes |
| mv_sof | output | 1 | First descriptor of a packet |
| mv_last | output | 1 | Last descriptor of a packet |
| mv_app | output | 160 | Latched application words of the packet |
| mv_done | input | 1 | Mover finished the transfer |
| idle | output | 1 | Walker idle flag |
| cmpl_pulse | output | 1 | One-cycle strobe per written-back descriptor |

## Verification
The two functions that can meet in one cycle are the tail comparison, which ends a walk, and a fresh tail write from software, which restarts it. The bench waits for the completion strobe of the first descriptor and raises the tail write on the next cycle, exactly when the walker is comparing against the old tail. It then judges the outcome at the ports. The scoreboard must see the second descriptor fetched, handed to the mover and written back, and `idle` must rise only after that second descriptor.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 11;
  localparam int APP_WORDS  = 5;
  localparam int LEN_W      = 23;
  localparam int W_BUF_LO   = 0;
  localparam int W_BUF_HI   = 1;
  localparam int W_NXT_LO   = 2;
  localparam int W_NXT_HI   = 3;
  localparam int W_CTL      = 4;
  localparam int W_STS      = 5;
  localparam int W_APP0     = 6;
  localparam int CTL_EOF    = 26;
  localparam int CTL_SOF    = 27;
  localparam int STS_DONE   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_XFER, S_WB, S_ADV
  } walk_st_e;

  // byte length carried in a control word
  function automatic logic [LEN_W-1:0] len_of(input logic [WORD_W-1:0] ctl);
    return ctl[LEN_W-1:0];
  endfunction

  // status value stored after a finished transfer
  function automatic logic [WORD_W-1:0] wb_status(input logic [WORD_W-1:0] ctl);
    logic [WORD_W-1:0] v;
    v = '0;
    v[LEN_W-1:0] = len_of(ctl);
    v[STS_DONE] = 1'b1;
    return v;
  endfunction

  // byte offset of descriptor word k
  function automatic logic [9:0] word_off(input logic [7:0] k);
    return {k, 2'b00};
  endfunction
endpackage

// File: rtl/sgw_desc_regs.sv
module sgw_desc_regs
  import sgw_pkg::*;
#(
  parameter int NW    = DESC_WORDS,
  localparam int IW   = $clog2(NW)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [IW-1:0]              cap_idx,
  input  logic [WORD_W-1:0]          cap_data,
  output logic [NW-1:0][WORD_W-1:0]  words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (cap_en && cap_idx == IW'(g)) words[g] <= cap_data;
    end
  end
endmodule

// File: rtl/sgw_app_hold.sv
module sgw_app_hold
  import sgw_pkg::*;
#(
  parameter int NA = APP_WORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NA-1:0][WORD_W-1:0] din,
  output logic [NA-1:0][WORD_W-1:0] dout
);
  for (genvar g = 0; g < NA; g++) begin : g_app
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout[g] <= '0;
      else if (load) dout[g] <= din[g];
    end
  end
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         cur_wr,
  input  logic [ADDR_W-1:0]            cur_addr,
  input  logic                         tail_wr,
  input  logic [ADDR_W-1:0]            tail_addr,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]            mem_wdata,
  input  logic [WORD_W-1:0]            mem_rdata,
  input  logic                         mem_ack,
  output logic                         mv_req,
  output logic [ADDR_W-1:0]            mv_addr,
  output logic [LEN_W-1:0]             mv_len,
  output logic                         mv_sof,
  output logic                         mv_last,
  output logic [APP_WORDS*WORD_W-1:0]  mv_app,
  input  logic                         mv_done,
  output logic                         idle,
  output logic                         cmpl_pulse
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  walk_st_e st, st_nx;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] cur, tail;
  logic idle_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  logic [APP_WORDS-1:0][WORD_W-1:0]  app_in, app_q;
  logic [WORD_W-1:0] ctl, sts;
  logic [63:0] buf64, nxt64;
  logic [IDX_W-1:0] sel;

  // named internal events
  logic ev_start, ev_cap, ev_last_word, ev_already_done;
  logic ev_wb_ack, ev_tail_hit, ev_app_load;

  assign ctl   = dw[W_CTL];
  assign sts   = dw[W_STS];
  assign buf64 = {dw[W_BUF_HI], dw[W_BUF_LO]};
  assign nxt64 = {dw[W_NXT_HI], dw[W_NXT_LO]};

  for (genvar g = 0; g < APP_WORDS; g++) begin : g_app_in
    assign app_in[g] = dw[W_APP0+g];
  end

  assign ev_start        = (st == S_IDLE) && run && !idle_q;
  assign ev_cap          = (st == S_FETCH) && mem_ack;
  assign ev_last_word    = ev_cap && (idx == IDX_W'(DESC_WORDS-1));
  assign ev_already_done = (st == S_CHECK) && sts[STS_DONE];
  assign ev_app_load     = (st == S_CHECK) && !sts[STS_DONE] && ctl[CTL_SOF];
  assign ev_wb_ack       = (st == S_WB) && mem_ack;
  assign ev_tail_hit     = (st == S_ADV) && (cur == tail);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (ev_start) st_nx = S_FETCH;
      S_FETCH: if (ev_last_word) st_nx = S_CHECK;
      S_CHECK: st_nx = ev_already_done ? S_IDLE : S_XFER;
      S_XFER:  if (mv_done) st_nx = S_WB;
      S_WB:    if (mem_ack) st_nx = S_ADV;
      S_ADV:   st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      cur    <= '0;
      tail   <= '0;
      idle_q <= 1'b1;
    end else begin
      st <= st_nx;
      if (ev_start)    idx <= '0;
      else if (ev_cap) idx <= idx + 1'b1;
      if (tail_wr) tail <= tail_addr;
      if (cur_wr && st == S_IDLE) cur <= cur_addr;
      else if (st == S_ADV)       cur <= nxt64[ADDR_W-1:0];
      if (tail_wr)                           idle_q <= 1'b0;
      else if (ev_already_done || ev_tail_hit) idle_q <= 1'b1;
    end
  end

  sgw_desc_regs #(.NW(DESC_WORDS)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(ev_cap), .cap_idx(idx),
    .cap_data(mem_rdata), .words(dw)
  );

  sgw_app_hold #(.NA(APP_WORDS)) u_app (
    .clk(clk), .rst_n(rst_n), .load(ev_app_load), .din(app_in), .dout(app_q)
  );

  assign sel        = (st == S_WB) ? IDX_W'(W_STS) : idx;
  assign mem_req    = (st == S_FETCH) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = cur + ADDR_W'(word_off(8'(sel)));
  assign mem_wdata  = wb_status(ctl);
  assign mv_req     = (st == S_XFER);
  assign mv_addr    = buf64[ADDR_W-1:0];
  assign mv_len     = len_of(ctl);
  assign mv_sof     = ctl[CTL_SOF];
  assign mv_last    = ctl[CTL_EOF];
  assign mv_app     = app_q;
  assign idle       = idle_q;
  assign cmpl_pulse = ev_wb_ack;

  logic unused_bits;
  assign unused_bits = ^{sts[STS_DONE-1:0], ctl[WORD_W-1:CTL_SOF+1], ctl[CTL_EOF-1:LEN_W],
                         buf64, nxt64};

  // assertions next to the logic they guard
  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> idle);

  p_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && (!run || idle_q)) |=> !mem_req);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  p_mv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_done) |=> mv_req);

  p_wb_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[STS_DONE] && mem_wdata[LEN_W-1:0] == dw[W_CTL][LEN_W-1:0]));

  p_cmpl_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |=> !cmpl_pulse);

  p_cmpl_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |-> (mem_we && mem_ack));

  p_done_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_already_done && !tail_wr) |=> (idle && !mv_req && !mem_req));

  p_tail_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tail_hit && tail_wr) |=> !idle);
endmodule

// File: tb/sgw_walker_tb.sv
`timescale 1ns/1ps
module sgw_walker_tb;
  localparam int AW = 64;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic run = 0, cur_wr = 0, tail_wr = 0;
  logic [AW-1:0] cur_addr = '0, tail_addr = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mv_req, mv_sof, mv_last, mv_done, idle, cmpl_pulse;
  logic [AW-1:0] mv_addr;
  logic [22:0] mv_len;
  logic [159:0] mv_app;

  sgw_walker #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cur_wr(cur_wr), .cur_addr(cur_addr),
    .tail_wr(tail_wr), .tail_addr(tail_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_sof(mv_sof),
    .mv_last(mv_last), .mv_app(mv_app), .mv_done(mv_done), .idle(idle),
    .cmpl_pulse(cmpl_pulse)
  );

  // memory model: one-cycle acknowledge, registered read data
  logic [31:0] mem [64];
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  // data mover model: done after a short delay
  int mv_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin mv_done <= 1'b0; mv_cnt <= 0; end
    else begin
      mv_done <= 1'b0;
      if (mv_req && !mv_done) begin
        if (mv_cnt == 2) begin mv_done <= 1'b1; mv_cnt <= 0; end
        else mv_cnt <= mv_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0, n_wr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  typedef struct {
    logic [63:0]  base;
    logic [63:0]  bufa;
    logic [22:0]  len;
    logic         sof;
    logic         last;
    logic [159:0] app;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] rd_q[$];
  int          rd_k = 0;
  logic [159:0] pkt_app = '0;

  // driver: write a descriptor into memory and push what it must produce
  task automatic put_desc(input logic [63:0] base, input logic [63:0] nxt,
                          input logic [22:0] len, input bit sof, input bit eof,
                          input logic [31:0] app_base, input bit done);
    int w;
    logic [63:0] bufa;
    logic [31:0] ctl;
    exp_t e;
    w = int'(base[7:2]);
    bufa = 64'h0000_0001_0000_1000 + base;
    ctl = {4'b0, sof, eof, 3'b0, len};
    mem[w]   <= bufa[31:0];
    mem[w+1] <= bufa[63:32];
    mem[w+2] <= nxt[31:0];
    mem[w+3] <= nxt[63:32];
    mem[w+4] <= ctl;
    mem[w+5] <= done ? 32'h8000_0000 : 32'h0;
    for (int i = 0; i < 5; i++) mem[w+6+i] <= app_base + 32'(i);
    rd_q.push_back(base);
    if (!done) begin
      if (sof) for (int i = 0; i < 5; i++) pkt_app[32*i +: 32] = app_base + 32'(i);
      e.base = base; e.bufa = bufa; e.len = len; e.sof = sof; e.last = eof; e.app = pkt_app;
      exp_q.push_back(e);
    end
  endtask

  // monitor: compare against the scoreboard away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack && !mem_we) begin
        if (rd_q.size() == 0) chk(0, "R3 unexpected read", mem_addr, 0);
        else begin
          chk(mem_addr == rd_q[0] + 64'(4*rd_k), "R3 fetch address", mem_addr, rd_q[0] + 64'(4*rd_k));
          rd_k++;
          if (rd_k == 11) begin rd_k = 0; void'(rd_q.pop_front()); end
        end
      end
      if (mv_req && mv_done) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected mover request", mv_addr, 0);
        else begin
          chk(mv_addr == exp_q[0].bufa, "R4 mover address", mv_addr, exp_q[0].bufa);
          chk({mv_len, mv_sof, mv_last} == {exp_q[0].len, exp_q[0].sof, exp_q[0].last},
              "R4 length/flags", {mv_len, mv_sof, mv_last}, {exp_q[0].len, exp_q[0].sof, exp_q[0].last});
          chk(mv_app == exp_q[0].app, "R5 app words", mv_app[63:0], exp_q[0].app[63:0]);
        end
      end
      if (mem_req && mem_ack && mem_we) begin
        n_wr++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected write", mem_addr, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.base + 64'd20, "R6 write address", mem_addr, e.base + 64'd20);
          chk(mem_wdata == ({9'b0, e.len} | 32'h8000_0000), "R6 write data", mem_wdata,
              {9'b0, e.len} | 32'h8000_0000);
          chk(cmpl_pulse, "R7 pulse with write ack", cmpl_pulse, 1);
        end
      end else if (cmpl_pulse) chk(0, "R7 stray pulse", 1, 0);
    end
  end

  task automatic set_cur(input logic [63:0] a);
    @(negedge clk); cur_wr = 1; cur_addr = a;
    @(negedge clk); cur_wr = 0;
  endtask

  task automatic set_tail(input logic [63:0] a);
    @(negedge clk); tail_wr = 1; tail_addr = a;
    @(negedge clk); tail_wr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(idle && !mem_req && !mv_req && !cmpl_pulse, "R1 reset state",
        {idle, mem_req, mv_req, cmpl_pulse}, 4'b1000);

    // chain of three: SOF, middle, EOF; tail at the third
    put_desc(64'h00, 64'h40, 23'h40,     1, 0, 32'h100, 0);
    put_desc(64'h40, 64'h80, 23'h7FFFFF, 0, 0, 32'h200, 0);
    put_desc(64'h80, 64'hC0, 23'h1,      0, 1, 32'h300, 0);
    set_cur(64'h00);
    set_tail(64'h80);
    chk(!idle, "R11 tail write clears idle", idle, 0);
    quiet = 1;
    repeat (20) begin @(negedge clk); if (mem_req) quiet = 0; end
    chk(quiet, "R2 no fetch while run low", !quiet, 0);
    run = 1;
    wait_idle();
    chk(exp_q.size() == 0 && rd_q.size() == 0, "R8 whole chain walked", exp_q.size(), 0);
    chk(mem[21] == 32'h807F_FFFF, "R8 middle status stored", mem[21], 32'h807F_FFFF);
    chk(n_wr == 3, "R7 one write per descriptor", n_wr, 3);

    // idle with run high: nothing starts
    quiet = 1;
    repeat (10) begin @(negedge clk); if (mem_req) quiet = 0; end
    chk(quiet, "R2 no fetch while idle", !quiet, 0);

    // already-complete descriptor
    put_desc(64'hC0, 64'h00, 23'h10, 1, 1, 32'h400, 1);
    set_cur(64'hC0);
    set_tail(64'h00);
    wait_idle();
    chk(idle && rd_q.size() == 0, "R9 stops on complete descriptor", idle, 1);
    chk(mem[53] == 32'h8000_0000, "R9 status untouched", mem[53], 32'h8000_0000);
    chk(n_wr == 3, "R9 no write-back", n_wr, 3);

    // tail write lands in the cycle of the tail comparison
    put_desc(64'h00, 64'h40, 23'h22, 1, 0, 32'h500, 0);
    put_desc(64'h40, 64'h80, 23'h33, 0, 1, 32'h600, 0);
    set_cur(64'h00);
    set_tail(64'h00);
    @(negedge clk);
    while (!cmpl_pulse) @(negedge clk);
    @(negedge clk);
    tail_wr = 1; tail_addr = 64'h40;
    @(negedge clk);
    tail_wr = 0;
    chk(!idle, "R10 tail write beats tail hit", idle, 0);
    wait_idle();
    chk(exp_q.size() == 0 && mem[21] == 32'h8000_0033, "R10 second descriptor done",
        mem[21], 32'h8000_0033);
    chk(idle, "R8 idle after new tail", idle, 1);
    finish_run();
  end
endmodule